// File: doc/BRIEF.md
# Serial Transmit Framer for 10 Mb/s Ethernet

This block turns a stream of frame bytes, offered by a transmit FIFO over a valid/ready handshake, into a serial NRZ bit stream. It produces one bit per clock cycle, where the clock is the line bit clock. Each frame is built from four parts:

- a fixed 64-bit lead-in, made of an alternating pattern followed by a pair of ones;
- the data bytes, serialized least significant bit first;
- a 32-bit frame check sequence;
- when a collision is reported, a 32-bit jam of ones that replaces the rest of the frame.

The frame check sequence is a CRC-32 that covers every data bit. It is shifted straight out of its register, high bit first. Line encoding, retry scheduling, the FIFO and the receive path live elsewhere.

A frame starts when data is offered while the line is idle. The block asks for the next byte one bit time before the current byte ends. If the FIFO has nothing to give at that moment, the frame is cut short and a sticky underrun flag is raised. A separate enable output marks exactly the cycles that carry frame bits.

Top module: `eth_tx_framer`

## Requirements
- R1: After reset, and between frames, `tx_en`, `tx_bit`, `in_ready` and `underrun` are all 0. If `in_valid` is high at a clock edge while the block is idle, the first frame bit appears in the following cycle.
- R2: A frame opens with 64 bits. Bits 0..61 alternate 1,0,1,0,… starting with 1, and bits 62 and 63 are both 1.
- R3: Data bytes follow the lead-in back to back, 8 cycles per byte, least significant bit first, with no gaps.
- R4: `in_ready` is high only in two places: in the final lead-in bit, and in bit 7 of a byte not marked last. It is never high while `col_in` is high. A byte is taken at a rising edge where `in_ready` and `in_valid` are both 1.
- R5: The check register is preset to all ones at frame start. For each data bit in line order it shifts left by one and is XORed with 0x04C11DB7 when (register bit 31 XOR data bit) is 1.
- R6: After the byte taken with `in_last` = 1, the complement of the check register is sent over 32 cycles, register bit 31 first, and then `tx_en` falls.
- R7: If `col_in` is high during a lead-in, data or check bit, the following 32 cycles carry 1s with `tx_en` high, and then the line goes idle. `col_in` has no effect during the jam or while idle.
- R8: If `in_ready` is high while `in_valid` is low, the current bit is the last one of the frame and `underrun` becomes 1. It stays 1 until the next frame starts.
- R9: `tx_en` is high for exactly the frame bits: 64 + 8·N + 32 cycles for an N-byte frame that is not interrupted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_data | input | 8 | Byte offered by the FIFO |
| in_valid | input | 1 | FIFO has a byte |
| in_last | input | 1 | Offered byte is the last of the frame |
| in_ready | output | 1 | Byte is taken at this edge if valid |
| col_in | input | 1 | Collision reported by the medium |
| tx_bit | output | 1 | Serial NRZ bit |
| tx_en | output | 1 | High while a frame bit is on `tx_bit` |
| underrun | output | 1 | Sticky: the last frame ended because the FIFO was empty |

## Verification
A wrong check-register value does not show up while data is going out. It appears only in the 32 bits that follow the last byte, so the error is seen after the whole frame has been sent. A slipped bit counter changes the frame length and moves the `in_ready` pulse, which is visible within one byte time. A stuck state shows up as a wrong `tx_en` length or a missing jam. The bench therefore compares whole captured frames bit by bit against an independently built reference, and separately checks the length, the number of bytes taken and the flag.

// File: rtl/eth_txf_pkg.sv
package eth_txf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_DATA = 3'd2,
    ST_FCS  = 3'd3,
    ST_JAM  = 3'd4
  } txf_state_e;

  typedef enum logic [1:0] {
    CRC_HOLD  = 2'd0,
    CRC_INIT  = 2'd1,
    CRC_FEED  = 2'd2,
    CRC_SHIFT = 2'd3
  } crc_op_e;
endpackage

// File: rtl/eth_txf_crc.sv
module eth_txf_crc
  import eth_txf_pkg::*;
#(
  parameter int          CRC_W    = 32,
  parameter logic [31:0] CRC_POLY = 32'h04C1_1DB7
) (
  input  logic    clk,
  input  logic    rst_n,
  input  crc_op_e op,
  input  logic    din,
  output logic    fcs_bit
);
  localparam logic [CRC_W-1:0] POLY_W = CRC_POLY[CRC_W-1:0];

  logic [CRC_W-1:0] crc_q, crc_n;
  logic             fb;

  assign fb = crc_q[CRC_W-1] ^ din;

  always_comb begin
    crc_n = crc_q;
    case (op)
      CRC_INIT:  crc_n = '1;
      CRC_FEED:  crc_n = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? POLY_W : '0);
      CRC_SHIFT: crc_n = {crc_q[CRC_W-2:0], 1'b0};
      default:   crc_n = crc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              crc_q <= '1;
    else if (op != CRC_HOLD) crc_q <= crc_n;
  end

  assign fcs_bit = ~crc_q[CRC_W-1];

  AST_CRC_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    (op == CRC_INIT) |=> (crc_q == '1)); // R5
endmodule

// File: rtl/eth_txf_shifter.sv
module eth_txf_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [BYTE_W-1:0] din,
  output logic              lsb
);
  logic [BYTE_W-1:0] sr_q, sr_n;

  always_comb begin
    sr_n = sr_q;
    if (load)       sr_n = din;
    else if (shift) sr_n = {1'b0, sr_q[BYTE_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              sr_q <= '0;
    else if (load || shift)  sr_q <= sr_n;
  end

  assign lsb = sr_q[0];
endmodule

// File: rtl/eth_txf_ctrl.sv
module eth_txf_ctrl
  import eth_txf_pkg::*;
#(
  parameter int PRE_BITS = 64,
  parameter int BYTE_W   = 8,
  parameter int FCS_BITS = 32,
  parameter int JAM_BITS = 32,
  parameter int CNT_W    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_last,
  input  logic             col_in,
  output txf_state_e       state_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             in_ready,
  output logic             load_o,
  output logic             shift_o,
  output crc_op_e          crc_op_o,
  output logic             underrun_o
);
  localparam logic [CNT_W-1:0] PRE_END  = CNT_W'(PRE_BITS - 1);
  localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FCS_END  = CNT_W'(FCS_BITS - 1);
  localparam logic [CNT_W-1:0] JAM_END  = CNT_W'(JAM_BITS - 1);

  txf_state_e       state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             last_q, last_n;
  logic             urun_q, urun_n;

  always_comb begin
    state_n  = state_q;
    cnt_n    = cnt_q;
    last_n   = last_q;
    urun_n   = urun_q;
    in_ready = 1'b0;
    load_o   = 1'b0;
    shift_o  = 1'b0;
    crc_op_o = CRC_HOLD;
    case (state_q)
      ST_IDLE: begin
        if (in_valid) begin
          state_n  = ST_PRE;
          cnt_n    = '0;
          urun_n   = 1'b0;
          crc_op_o = CRC_INIT;
        end
      end
      ST_PRE: begin
        if (col_in) begin
          state_n = ST_JAM;
          cnt_n   = '0;
        end else if (cnt_q == PRE_END) begin
          in_ready = 1'b1;
          cnt_n    = '0;
          if (in_valid) begin
            state_n = ST_DATA;
            load_o  = 1'b1;
            last_n  = in_last;
          end else begin
            state_n = ST_IDLE;
            urun_n  = 1'b1;
          end
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      ST_DATA: begin
        crc_op_o = CRC_FEED;
        if (col_in) begin
          state_n = ST_JAM;
          cnt_n   = '0;
        end else if (cnt_q == BYTE_END) begin
          cnt_n = '0;
          if (last_q) begin
            state_n = ST_FCS;
          end else begin
            in_ready = 1'b1;
            if (in_valid) begin
              load_o = 1'b1;
              last_n = in_last;
            end else begin
              state_n = ST_IDLE;
              urun_n  = 1'b1;
            end
          end
        end else begin
          cnt_n   = cnt_q + 1'b1;
          shift_o = 1'b1;
        end
      end
      ST_FCS: begin
        crc_op_o = CRC_SHIFT;
        if (col_in) begin
          state_n = ST_JAM;
          cnt_n   = '0;
        end else if (cnt_q == FCS_END) begin
          state_n = ST_IDLE;
          cnt_n   = '0;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      ST_JAM: begin
        if (cnt_q == JAM_END) begin
          state_n = ST_IDLE;
          cnt_n   = '0;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      default: begin
        state_n = ST_IDLE;
        cnt_n   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      last_q  <= 1'b0;
      urun_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      last_q  <= last_n;
      urun_q  <= urun_n;
    end
  end

  assign state_o    = state_q;
  assign cnt_o      = cnt_q;
  assign underrun_o = urun_q;

  AST_COL_TO_JAM: assert property (@(posedge clk) disable iff (!rst_n)
    (col_in && (state_q inside {ST_PRE, ST_DATA, ST_FCS})) |=> (state_q == ST_JAM)); // R7
  AST_JAM_IGNORES_COL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_JAM && cnt_q != JAM_END) |=> (state_q == ST_JAM)); // R7
  AST_URUN_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(urun_q) |-> (state_q == ST_IDLE)); // R8
  AST_BYTE_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA) |-> (cnt_q <= BYTE_END)); // R3
endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer
  import eth_txf_pkg::*;
#(
  parameter int          PRE_BITS = 64,
  parameter int          BYTE_W   = 8,
  parameter int          CRC_W    = 32,
  parameter int          JAM_BITS = 32,
  parameter logic [31:0] CRC_POLY = 32'h04C1_1DB7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  input  logic              col_in,
  output logic              tx_bit,
  output logic              tx_en,
  output logic              underrun
);
  localparam int MAX_A  = (PRE_BITS > CRC_W) ? PRE_BITS : CRC_W;
  localparam int MAX_B  = (JAM_BITS > BYTE_W) ? JAM_BITS : BYTE_W;
  localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W  = $clog2(MAX_C);
  localparam logic [CNT_W-1:0] SYNC_AT = CNT_W'(PRE_BITS - 2);

  txf_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             load, shift, data_bit, fcs_bit;
  crc_op_e          crc_op;

  eth_txf_ctrl #(
    .PRE_BITS (PRE_BITS),
    .BYTE_W   (BYTE_W),
    .FCS_BITS (CRC_W),
    .JAM_BITS (JAM_BITS),
    .CNT_W    (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_last    (in_last),
    .col_in     (col_in),
    .state_o    (state),
    .cnt_o      (cnt),
    .in_ready   (in_ready),
    .load_o     (load),
    .shift_o    (shift),
    .crc_op_o   (crc_op),
    .underrun_o (underrun)
  );

  eth_txf_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .shift (shift),
    .din   (in_data),
    .lsb   (data_bit)
  );

  eth_txf_crc #(.CRC_W(CRC_W), .CRC_POLY(CRC_POLY)) u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (crc_op),
    .din     (data_bit),
    .fcs_bit (fcs_bit)
  );

  always_comb begin
    case (state)
      ST_PRE:  tx_bit = (cnt < SYNC_AT) ? ~cnt[0] : 1'b1;
      ST_DATA: tx_bit = data_bit;
      ST_FCS:  tx_bit = fcs_bit;
      ST_JAM:  tx_bit = 1'b1;
      default: tx_bit = 1'b0;
    endcase
  end

  assign tx_en = (state != ST_IDLE);

  AST_START_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> $past(in_valid)); // R1
  AST_READY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (tx_en && !col_in)); // R4
  AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !tx_bit); // R1
endmodule

// File: tb/eth_tx_framer_tb.sv
`timescale 1ns/1ps
module eth_tx_framer_tb;
  logic       clk, rst_n;
  logic [7:0] in_data;
  logic       in_valid, in_last, in_ready, col_in;
  logic       tx_bit, tx_en, underrun;

  int n_chk = 0;
  int n_fail = 0;

  eth_tx_framer u_dut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .in_ready(in_ready), .col_in(col_in),
    .tx_bit(tx_bit), .tx_en(tx_en), .underrun(underrun)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {byte count[19:16], first byte[15:8], increment[7:0]}
  localparam int NVEC = 6;
  localparam logic [19:0] VEC [NVEC] = '{
    {4'd1,  8'h00, 8'h00},
    {4'd2,  8'hFF, 8'h00},
    {4'd3,  8'hA5, 8'h11},
    {4'd5,  8'h01, 8'h02},
    {4'd8,  8'h80, 8'h13},
    {4'd15, 8'h3C, 8'h07}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  // col_lo < 0: no collision. stall > 0: only 'stall' bytes are offered, none marked last.
  task automatic run_frame(input int n, input logic [7:0] first, input logic [7:0] step,
                           input int col_lo, input int col_hi, input int stall);
    logic [7:0]  bytes [16];
    logic        expb [700];
    logic        got  [700];
    logic [31:0] c;
    int k, L, fi, lat, takes, idx, rdy_col, ndata, e_pre, e_dat, e_fcs, e_all;
    bit take, seen;
    for (int i = 0; i < 16; i++) bytes[i] = first + 8'(i) * step;
    ndata = (stall > 0) ? stall : n;
    k = 0;
    for (int i = 0; i < 62; i++) expb[k++] = (i % 2 == 0);
    expb[k++] = 1'b1; expb[k++] = 1'b1;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin
        expb[k++] = bytes[i][b];
        if (c[31] ^ bytes[i][b]) c = {c[30:0], 1'b0} ^ 32'h04C1_1DB7;
        else                     c = {c[30:0], 1'b0};
      end
    for (int i = 0; i < 32; i++) expb[k++] = ~c[31-i];
    L = k;
    if (stall > 0) L = 64 + 8 * stall;
    if (col_lo >= 0) begin
      L = col_lo + 1 + 32;
      for (int j = col_lo + 1; j < L; j++) expb[j] = 1'b1;
    end

    @(posedge clk); #1;
    idx = 0; in_valid = 1'b1; in_data = bytes[0];
    in_last = (stall == 0 && n == 1);
    fi = 0; lat = 0; takes = 0; rdy_col = 0; seen = 1'b0;
    for (int cyc = 0; cyc < 800; cyc++) begin
      @(negedge clk);
      if (tx_en) begin
        seen = 1'b1;
        got[fi] = tx_bit;
        fi++;
      end else if (seen) begin
        break;
      end else begin
        lat++;
      end
      if (in_ready && col_in) rdy_col++;
      take = in_ready && in_valid;
      @(posedge clk); #1;
      if (take) begin idx++; takes++; end
      in_valid = (stall > 0) ? (idx < stall) : (idx < n);
      in_data  = bytes[idx % 16];
      in_last  = (stall == 0 && idx == n - 1);
      col_in   = seen && (col_lo >= 0) && (fi >= col_lo) && (fi <= col_hi);
      if (col_lo >= 0 && fi >= col_lo) in_valid = 1'b0;
    end
    in_valid = 1'b0; in_last = 1'b0; col_in = 1'b0;

    e_pre = 0; e_dat = 0; e_fcs = 0; e_all = 0;
    for (int j = 0; j < fi && j < L; j++) begin
      if (got[j] !== expb[j]) begin
        e_all++;
        if (j < 64) e_pre++;
        else if (j < 64 + 8 * ndata) e_dat++;
        else e_fcs++;
      end
    end
    chk(lat == 1, "R1", "start latency", lat, 1);
    chk(fi == L, "R9", "tx_en length", fi, L);
    chk(tx_bit == 1'b0 && in_ready == 1'b0, "R1", "idle outputs", {tx_bit, in_ready}, 0);
    if (col_lo >= 0) begin
      chk(e_all == 0, "R7", "jam stream mismatches", e_all, 0);
      chk(rdy_col == 0, "R4", "ready during collision", rdy_col, 0);
    end else begin
      chk(e_pre == 0, "R2", "lead-in mismatches", e_pre, 0);
      chk(e_dat == 0, "R3", "data bit mismatches", e_dat, 0);
      chk(takes == ndata, "R4", "bytes taken", takes, ndata);
      if (stall == 0) chk(e_fcs == 0, "R6", "check bits per R5 mismatches", e_fcs, 0);
    end
    chk(underrun == (stall > 0), "R8", "underrun flag", underrun, (stall > 0));
  endtask

  initial begin
    rst_n = 1'b0; in_data = '0; in_valid = 1'b0; in_last = 1'b0; col_in = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(tx_en == 0 && tx_bit == 0 && in_ready == 0 && underrun == 0,
        "R1", "reset outputs", {tx_en, tx_bit, in_ready, underrun}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);

    for (int v = 0; v < NVEC; v++) begin
      run_frame(int'(VEC[v][19:16]), VEC[v][15:8], VEC[v][7:0], -1, -1, 0);
      repeat (2) @(posedge clk);
    end

    // R7: collision in lead-in, in data, in check field, repeated during jam
    run_frame(4, 8'h5A, 8'h01, 10, 10, 0);
    repeat (2) @(posedge clk);
    run_frame(4, 8'h5A, 8'h01, 73, 73, 0);
    repeat (2) @(posedge clk);
    run_frame(2, 8'hC3, 8'h10, 85, 85, 0);
    repeat (2) @(posedge clk);
    run_frame(6, 8'h11, 8'h22, 70, 90, 0);
    repeat (2) @(posedge clk);

    // R7: collision while idle has no effect
    @(posedge clk); #1 col_in = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(tx_en == 0 && tx_bit == 0, "R7", "idle collision output", {tx_en, tx_bit}, 0);
    end
    @(posedge clk); #1 col_in = 1'b0;

    // R8: FIFO empty after two bytes, flag sticky, cleared by next frame
    run_frame(9, 8'h77, 8'h01, -1, -1, 2);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(underrun == 1'b1 && tx_en == 1'b0, "R8", "flag held while idle", underrun, 1);
    run_frame(3, 8'h0F, 8'h0F, -1, -1, 0);
    repeat (2) @(posedge clk);

    // R1: reset in mid-frame returns the outputs to idle
    @(posedge clk); #1 in_valid = 1'b1; in_data = 8'hAA; in_last = 1'b0;
    repeat (20) @(posedge clk);
    #1 rst_n = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    chk(tx_en == 0 && in_ready == 0 && underrun == 0, "R1", "mid-frame reset",
        {tx_en, in_ready, underrun}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    run_frame(1, 8'hE7, 8'h00, -1, -1, 0);

    summary();
  end
endmodule